// File: doc/BRIEF.md
# Processor Core Power State Controller

This block is the clock-control state machine that moves a processor core between three power states: active, halted and power-down. A halt request is held until the core reports that its bus traffic has finished and its store and push buffers are empty. Only then does the block enter halted, switch off the functional-unit clock enables and raise a halted status. While halted, a separate stop request carries the block on into power-down, where a stopped status is raised as well. The time base keeps its own clock enable, so it can run in every state. It can be switched off while powered down.

Wake-up returns the block to active. A wake can come from a general wake request, from dropping the halt request, or from a time-base event. A time-base event counts only when the time base runs from an independent clock and that clock is enabled. Power-down is never left while the main clock is reported as stopped. Stopped always falls one cycle before halted. In active, each functional unit that reports itself idle has its clock enable withdrawn automatically. All status outputs and clock enables come straight from registers. All control pins are plain levels, with no stream handshake.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset, halted_o and stopped_o are 0, every bit of unit_clk_en_o is 1 and tb_clk_en_o is 1.
- R2: halted_o rises on the first clock edge at which halt_req_i and drain_done_i are both 1 in the active state. A halt request without drain-done, or drain-done without a halt request, leaves the block active.
- R3: unit_clk_en_o falls to all zeros in the same cycle that halted_o rises. It stays all zeros while halted_o is 1.
- R4: stopped_o rises on the edge after a cycle in which halted_o and stop_req_i are both 1. stop_req_i has no effect in the active state.
- R5: In active, with dynamic gating enabled, bit i of unit_clk_en_o equals the inverse of unit_idle_i[i] from the previous edge.
- R6: In halted, wake_req_i = 1 or halt_req_i = 0 makes halted_o fall at the next edge. The unit enables return in that same cycle.
- R7: In power-down, no input leaves the state while mclk_running_i is 0.
- R8: Leaving power-down, stopped_o falls first and halted_o stays 1 for that cycle. If the exit was caused by a wake, halted_o falls at the following edge. If only stop_req_i was removed while halt_req_i stays 1, the block remains halted.
- R9: tb_clk_en_o is 0 only while the block is in power-down with tb_disable_i = 1. It is registered together with the state.
- R10: tb_wake_i acts as a wake only when tb_indep_clk_i = 1 and tb_clk_en_o = 1. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock-control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | Request to enter halted (level) |
| drain_done_i | input | 1 | Bus idle and buffers flushed (pulse or level) |
| stop_req_i | input | 1 | Request to continue into power-down (level) |
| wake_req_i | input | 1 | General wake request |
| tb_wake_i | input | 1 | Time-base event (e.g. decrementer) |
| tb_indep_clk_i | input | 1 | Time base runs from an independent clock |
| tb_disable_i | input | 1 | Stop time base clock while powered down |
| mclk_running_i | input | 1 | Main clock has been restarted |
| unit_idle_i | input | NUM_UNITS | Per-unit idle indication |
| unit_clk_en_o | output | NUM_UNITS | Per-unit functional clock enable |
| tb_clk_en_o | output | 1 | Time base clock enable |
| halted_o | output | 1 | Halted status |
| stopped_o | output | 1 | Stopped (power-down) status |

## Verification
Every 4-bit idle pattern is applied in active to show that the unit enables follow each unit on its own. Halt entry is tried with the request alone, with drain alone, and with both together, which shows that both are needed. Power-down exit is tried with a wake while the main clock is down, with a wake after it returns, and with stop removed while the halt request is held. These cases separate the clock gate, the one-cycle stopped-before-halted order, and the return to halted. A sweep over all four combinations of the independent-clock and time-base-disable inputs shows that a time-base event wakes the block only in the one combination where it may.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE = 2'd0,
    PS_HALTED = 2'd1,
    PS_PDOWN  = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual (
  input  logic wake_req_i,
  input  logic tb_wake_i,
  input  logic tb_indep_clk_i,
  input  logic tb_running_i,
  output logic wake_any_o
);

  logic tb_wake_ok;

  // A time-base event counts only when the time base keeps its own clock
  // and that clock is currently enabled.
  always_comb begin
    tb_wake_ok = tb_wake_i & tb_indep_clk_i & tb_running_i;
    wake_any_o = wake_req_i | tb_wake_ok;
  end

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req_i,
  input  logic       drain_done_i,
  input  logic       stop_req_i,
  input  logic       wake_any_i,
  input  logic       mclk_running_i,
  output pwr_state_e state_nxt_o,
  output logic       halted_o,
  output logic       stopped_o
);

  pwr_state_e state_q;
  pwr_state_e state_d;
  logic       wake_pend_q;
  logic       wake_pend_d;
  logic       pd_leave;

  always_comb begin
    state_d     = state_q;
    wake_pend_d = 1'b0;
    pd_leave    = 1'b0;
    unique case (state_q)
      PS_ACTIVE: begin
        if (halt_req_i && drain_done_i) state_d = PS_HALTED;
      end
      PS_HALTED: begin
        if (wake_pend_q || wake_any_i || !halt_req_i) state_d = PS_ACTIVE;
        else if (stop_req_i)                          state_d = PS_PDOWN;
      end
      PS_PDOWN: begin
        // Exit only once the main clock is back; always via halted.
        pd_leave = mclk_running_i && (!stop_req_i || wake_any_i || !halt_req_i);
        if (pd_leave) begin
          state_d     = PS_HALTED;
          wake_pend_d = wake_any_i;
        end
      end
      default: state_d = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_ACTIVE;
      wake_pend_q <= 1'b0;
      halted_o    <= 1'b0;
      stopped_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      wake_pend_q <= wake_pend_d;
      halted_o    <= (state_d == PS_HALTED) || (state_d == PS_PDOWN);
      stopped_o   <= (state_d == PS_PDOWN);
    end
  end

  assign state_nxt_o = state_d;

endmodule

// File: rtl/pwr_clk_enables.sv
module pwr_clk_enables
  import pwr_ctl_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter bit DPM_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pwr_state_e           state_nxt_i,
  input  logic [NUM_UNITS-1:0] unit_idle_i,
  input  logic                 tb_disable_i,
  output logic [NUM_UNITS-1:0] unit_clk_en_o,
  output logic                 tb_clk_en_o
);

  logic run_units;
  assign run_units = (state_nxt_i == PS_ACTIVE);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic en_d;
    if (DPM_EN) begin : g_dpm
      assign en_d = run_units & ~unit_idle_i[u];
    end else begin : g_nodpm
      assign en_d = run_units;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) unit_clk_en_o[u] <= 1'b1;
      else        unit_clk_en_o[u] <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_clk_en_o <= 1'b1;
    else        tb_clk_en_o <= !((state_nxt_i == PS_PDOWN) && tb_disable_i);
  end

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter bit DPM_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req_i,
  input  logic                 drain_done_i,
  input  logic                 stop_req_i,
  input  logic                 wake_req_i,
  input  logic                 tb_wake_i,
  input  logic                 tb_indep_clk_i,
  input  logic                 tb_disable_i,
  input  logic                 mclk_running_i,
  input  logic [NUM_UNITS-1:0] unit_idle_i,
  output logic [NUM_UNITS-1:0] unit_clk_en_o,
  output logic                 tb_clk_en_o,
  output logic                 halted_o,
  output logic                 stopped_o
);

  logic       wake_any;
  pwr_state_e state_nxt;

  pwr_wake_qual wake_i (
    .wake_req_i     (wake_req_i),
    .tb_wake_i      (tb_wake_i),
    .tb_indep_clk_i (tb_indep_clk_i),
    .tb_running_i   (tb_clk_en_o),
    .wake_any_o     (wake_any)
  );

  pwr_state_fsm fsm_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_req_i     (halt_req_i),
    .drain_done_i   (drain_done_i),
    .stop_req_i     (stop_req_i),
    .wake_any_i     (wake_any),
    .mclk_running_i (mclk_running_i),
    .state_nxt_o    (state_nxt),
    .halted_o       (halted_o),
    .stopped_o      (stopped_o)
  );

  pwr_clk_enables #(
    .NUM_UNITS (NUM_UNITS),
    .DPM_EN    (DPM_EN)
  ) clken_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_nxt_i   (state_nxt),
    .unit_idle_i   (unit_idle_i),
    .tb_disable_i  (tb_disable_i),
    .unit_clk_en_o (unit_clk_en_o),
    .tb_clk_en_o   (tb_clk_en_o)
  );

endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk #(
  parameter int NUM_UNITS = 4,
  parameter bit DPM_EN    = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 halt_req_i,
  input logic                 drain_done_i,
  input logic                 stop_req_i,
  input logic                 wake_req_i,
  input logic                 tb_wake_i,
  input logic                 tb_indep_clk_i,
  input logic                 mclk_running_i,
  input logic [NUM_UNITS-1:0] unit_idle_i,
  input logic [NUM_UNITS-1:0] unit_clk_en_o,
  input logic                 halted_o,
  input logic                 stopped_o
);

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  p_halt_after_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $rose(halted_o)) |-> $past(halt_req_i && drain_done_i));

  p_units_off_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (unit_clk_en_o == '0));

  p_stop_via_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $rose(stopped_o)) |-> $past(halted_o && stop_req_i));

  p_stopped_in_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |-> halted_o);

  p_dyn_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && DPM_EN && !halted_o) |-> (unit_clk_en_o == ~$past(unit_idle_i)));

  p_pd_exit_mclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $fell(stopped_o)) |-> $past(mclk_running_i));

  p_stop_drops_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $fell(stopped_o)) |-> halted_o);

  p_tb_wake_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_o && !tb_indep_clk_i && !wake_req_i && stop_req_i && halt_req_i)
      |=> stopped_o);

endmodule

bind pwr_state_ctl pwr_ctl_chk #(
  .NUM_UNITS (NUM_UNITS),
  .DPM_EN    (DPM_EN)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .halt_req_i     (halt_req_i),
  .drain_done_i   (drain_done_i),
  .stop_req_i     (stop_req_i),
  .wake_req_i     (wake_req_i),
  .tb_wake_i      (tb_wake_i),
  .tb_indep_clk_i (tb_indep_clk_i),
  .mclk_running_i (mclk_running_i),
  .unit_idle_i    (unit_idle_i),
  .unit_clk_en_o  (unit_clk_en_o),
  .halted_o       (halted_o),
  .stopped_o      (stopped_o)
);

// File: tb/pwr_state_ctl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctl_tb_top;

  localparam int NU = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          halt_req = 0, drain_done = 0, stop_req = 0, wake_req = 0;
  logic          tb_wake = 0, tb_indep = 0, tb_dis = 0, mclk_run = 1;
  logic [NU-1:0] idle = '0;
  logic [NU-1:0] unit_en;
  logic          tb_en, halted, stopped;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_state_ctl #(.NUM_UNITS(NU), .DPM_EN(1'b1)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .halt_req_i (halt_req), .drain_done_i (drain_done),
    .stop_req_i (stop_req), .wake_req_i (wake_req),
    .tb_wake_i (tb_wake), .tb_indep_clk_i (tb_indep),
    .tb_disable_i (tb_dis), .mclk_running_i (mclk_run),
    .unit_idle_i (idle), .unit_clk_en_o (unit_en),
    .tb_clk_en_o (tb_en), .halted_o (halted), .stopped_o (stopped)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic enter_halt();
    halt_req = 1; drain_done = 1;
    step();
    drain_done = 0;
  endtask

  task automatic enter_pd();
    enter_halt();
    stop_req = 1;
    step();
  endtask

  task automatic release_all();
    halt_req = 0; stop_req = 0; wake_req = 0; tb_wake = 0;
    tb_dis = 0; tb_indep = 0; mclk_run = 1;
    step(); step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 halted", halted, 0);
    chk("R1 stopped", stopped, 0);
    chk("R1 unit_en", unit_en, 15);
    chk("R1 tb_en", tb_en, 1);

    // R5 every idle pattern
    for (int p = 0; p < 16; p++) begin
      idle = p[NU-1:0];
      step();
      chk("R5 unit_en", unit_en, (~p) & 15);
    end
    idle = '0; step();

    // R4 stop in active has no effect
    stop_req = 1; step(); step();
    chk("R4 stop active stopped", stopped, 0);
    chk("R4 stop active halted", halted, 0);
    stop_req = 0;

    // R2 drain alone, request alone, both
    drain_done = 1; step();
    chk("R2 drain only", halted, 0);
    drain_done = 0; halt_req = 1;
    step(); step(); step();
    chk("R2 request only", halted, 0);
    drain_done = 1; step(); drain_done = 0;
    chk("R2 both", halted, 1);
    chk("R3 units off at halt", unit_en, 0);
    step();
    chk("R3 units stay off", unit_en, 0);

    // R6 wake from halted
    wake_req = 1; step(); wake_req = 0;
    chk("R6 wake halted", halted, 0);
    chk("R6 units back", unit_en, 15);
    step();
    chk("R6 stays active without drain", halted, 0);
    halt_req = 0; step();

    // R6 drop halt request
    enter_halt();
    chk("R6 halted again", halted, 1);
    halt_req = 0; step();
    chk("R6 halt dropped", halted, 0);

    // R4 power-down entry
    enter_pd();
    chk("R4 stopped", stopped, 1);
    chk("R4 halted in pd", halted, 1);
    chk("R3 units off pd", unit_en, 0);

    // R7 wake ignored while main clock down
    mclk_run = 0; wake_req = 1; step(); step();
    chk("R7 wake no mclk", stopped, 1);
    mclk_run = 1; step(); wake_req = 0;
    chk("R8 stopped falls first", stopped, 0);
    chk("R8 halted held", halted, 1);
    step();
    chk("R8 halted falls after", halted, 0);
    release_all();

    // R8 stop removed with halt request held
    enter_pd();
    mclk_run = 0; stop_req = 0; step();
    chk("R7 stop drop no mclk", stopped, 1);
    mclk_run = 1; step();
    chk("R8 back to halted stopped", stopped, 0);
    chk("R8 back to halted halted", halted, 1);
    step();
    chk("R8 remains halted", halted, 1);
    release_all();
    chk("R6 active after release", halted, 0);

    // R9 / R10 sweep over independent clock and disable
    for (int ind = 0; ind < 2; ind++) begin
      for (int dis = 0; dis < 2; dis++) begin
        tb_indep = ind[0]; tb_dis = dis[0];
        enter_halt();
        chk("R9 tb_en halted", tb_en, 1);
        stop_req = 1; step();
        chk("R9 tb_en pd", tb_en, (dis == 0) ? 1 : 0);
        tb_wake = 1; step(); tb_wake = 0;
        chk("R10 tb wake", stopped, (ind == 1 && dis == 0) ? 0 : 1);
        if (stopped) begin
          wake_req = 1; step(); wake_req = 0;
        end
        step();
        chk("R10 active after wake", halted, 0);
        release_all();
      end
    end
    chk("R9 tb_en released", tb_en, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule